// File: doc/BRIEF.md
# Four-Phase Bus Read Handshake Sender

This block sits on the sending side of a serial output path. It guards words that go to a host bus reader instead of the default link. Software on the reader side raises a request flag when it wants a word. The block holds one word supplied on a valid strobe. Once the serial transmitter is free and the request has been seen, it raises its own offer flag. When the downstream ready line allows, it issues a single write strobe with the word. It then treats the reader's falling request as proof that the word was received, and lowers its offer flag to close the four-phase cycle. No other word can be written until that cycle has closed and the reader has asked again.

The request input comes from another clock domain and passes through a two-stage synchroniser before the controller uses it. If the reader withdraws its request after the offer but before the word has gone out, the block flags a protocol error for one cycle. It then lowers its flag, keeps the word and offers it again on the next request. While the destination select points at the link, this controller ignores incoming words and stays idle with its flag low, because the link path does not need this exchange.

The controller is a Moore machine with six states:
- IDLE: no word is held.
- ARM: a word is held, waiting for a free transmitter and a request.
- OFFER: the flag is up, waiting for downstream ready.
- WRITE: the one-cycle write strobe.
- SENT: the flag is up, waiting for the request to fall.
- ABORT: the one-cycle error pulse.

Its transitions are:
- capture: IDLE to ARM on a valid strobe with the bus destination selected.
- offer: ARM to OFFER when the transmitter is free and the synchronised request is high.
- write: OFFER to WRITE when downstream is ready.
- launch: WRITE to SENT, unconditionally.
- release: SENT to IDLE when the request is low.
- withdraw: OFFER to ABORT when the request is low.
- retry: ABORT to ARM, unconditionally.

Top module: `hs4_bus_sender`

## Requirements
- R1: While reset is asserted (rst_n low) and in the first cycle after it is released, snd_flag, wr_stb and proto_err are all 0.
- R2: In IDLE, a cycle with word_valid=1 and dest_bus=1 captures word_in. Strobes while a word is held are ignored, so the word written is the first one captured.
- R3: With dest_bus=0 (link destination), word_valid has no effect: snd_flag stays 0 and no wr_stb occurs, whatever the reader request does.
- R4: snd_flag rises only after the previous clock saw a held word, ser_free=1 and a synchronised request of 1. With ser_free=0 or the request at 0 it stays low.
- R5: wr_stb is a single-cycle pulse. It occurs only while snd_flag=1 and only after a cycle with dn_ready=1, and wr_data then equals the captured word.
- R6: After the write, snd_flag stays 1 until the synchronised request is 0, and falls at the next clock.
- R7: The request input passes through two register stages. After rdr_req_async falls, snd_flag is still 1 after two rising edges and is 0 after the third.
- R8: At most one wr_stb occurs per raising of snd_flag. A new offer needs a newly captured word and a new request after snd_flag has returned to 0.
- R9: If the synchronised request falls while offering and before the write, proto_err pulses for exactly one cycle with snd_flag low. The word is kept and is written when the request returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dest_bus | input | 1 | 1: words go to the bus reader; 0: link destination, handshake bypassed |
| word_in | input | DATA_W | Word to send |
| word_valid | input | 1 | Strobe marking word_in as valid |
| ser_free | input | 1 | Serial transmitter ready and its buffer empty |
| rdr_req_async | input | 1 | Reader request flag, asynchronous |
| dn_ready | input | 1 | Downstream able to accept a word |
| snd_flag | output | 1 | Sender offer flag to the reader |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_data | output | DATA_W | Word being written |
| proto_err | output | 1 | One-cycle pulse when the request is withdrawn before the write |

## Verification
Some rules are checked by the assertions on every cycle:
- the flag rises only after a free transmitter and a request were seen;
- each write is a single pulse made under the raised flag after a ready cycle;
- no raising of the flag carries more than one write;
- the flag falls only after a low request;
- an error pulse lasts one cycle with the flag low.

Other behaviour can only be shown by the bench scenarios, because each depends on what a particular sequence of stimulus should produce:
- that a strobe arriving during a transfer is ignored;
- that link-destination words leave the block idle;
- the exact three-edge latency from a falling request to a falling flag;
- that a withdrawn offer delivers its retained word later.

// File: rtl/hs4_pkg.sv
package hs4_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARM   = 3'd1,
        ST_OFFER = 3'd2,
        ST_WRITE = 3'd3,
        ST_SENT  = 3'd4,
        ST_ABORT = 3'd5
    } hs4_state_t;

endpackage

// File: rtl/hs4_sync.sv
module hs4_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[LAST];
endmodule

// File: rtl/hs4_word_hold.sv
module hs4_word_hold #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/hs4_fsm.sv
module hs4_fsm
    import hs4_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dest_bus,
    input  logic word_valid,
    input  logic ser_free,
    input  logic req_s,
    input  logic dn_ready,
    output logic capture,
    output logic flag,
    output logic write,
    output logic err
);
    hs4_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (word_valid && dest_bus) state_nx = ST_ARM;
            ST_ARM:   if (ser_free && req_s)      state_nx = ST_OFFER;
            ST_OFFER: begin
                if (!req_s)        state_nx = ST_ABORT;
                else if (dn_ready) state_nx = ST_WRITE;
            end
            ST_WRITE: state_nx = ST_SENT;
            ST_SENT:  if (!req_s) state_nx = ST_IDLE;
            ST_ABORT: state_nx = ST_ARM;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        capture = 1'b0;
        flag    = 1'b0;
        write   = 1'b0;
        err     = 1'b0;
        unique case (state)
            ST_IDLE:  capture = word_valid && dest_bus;
            ST_ARM:   ;
            ST_OFFER: flag = 1'b1;
            ST_WRITE: begin
                flag  = 1'b1;
                write = 1'b1;
            end
            ST_SENT:  flag = 1'b1;
            ST_ABORT: err = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/hs4_bus_sender.sv
module hs4_bus_sender #(
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dest_bus,
    input  logic [DATA_W-1:0] word_in,
    input  logic              word_valid,
    input  logic              ser_free,
    input  logic              rdr_req_async,
    input  logic              dn_ready,
    output logic              snd_flag,
    output logic              wr_stb,
    output logic [DATA_W-1:0] wr_data,
    output logic              proto_err
);
    logic req_s;
    logic capture;

    hs4_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (rdr_req_async),
        .q_sync  (req_s)
    );

    hs4_word_hold #(.DATA_W(DATA_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (capture),
        .d     (word_in),
        .q     (wr_data)
    );

    hs4_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .dest_bus   (dest_bus),
        .word_valid (word_valid),
        .ser_free   (ser_free),
        .req_s      (req_s),
        .dn_ready   (dn_ready),
        .capture    (capture),
        .flag       (snd_flag),
        .write      (wr_stb),
        .err        (proto_err)
    );
endmodule

// File: rtl/hs4_sva.sv
module hs4_sva (
    input logic clk,
    input logic rst_n,
    input logic req_s,
    input logic ser_free,
    input logic dn_ready,
    input logic snd_flag,
    input logic wr_stb,
    input logic proto_err
);
    logic writes_in_offer;

    always_ff @(posedge clk) begin
        if (!rst_n || !snd_flag) writes_in_offer <= 1'b0;
        else if (wr_stb)         writes_in_offer <= 1'b1;
    end

    p_flag_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(snd_flag) |-> ($past(req_s) && $past(ser_free)));

    p_wr_under_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> snd_flag);

    p_wr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    p_wr_after_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(dn_ready));

    p_flag_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(snd_flag) |-> !$past(req_s));

    p_one_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !writes_in_offer);

    p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> (!snd_flag && !wr_stb));

    p_err_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> !proto_err);
endmodule

bind hs4_bus_sender hs4_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_s     (req_s),
    .ser_free  (ser_free),
    .dn_ready  (dn_ready),
    .snd_flag  (snd_flag),
    .wr_stb    (wr_stb),
    .proto_err (proto_err)
);

// File: tb/tb_hs4_bus_sender.sv
module tb_hs4_bus_sender;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dest_bus = 1'b1;
    logic [DW-1:0] word_in = '0;
    logic          word_valid = 1'b0;
    logic          ser_free = 1'b1;
    logic          rdr_req_async = 1'b0;
    logic          dn_ready = 1'b1;
    logic          snd_flag, wr_stb, proto_err;
    logic [DW-1:0] wr_data;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    int err_cnt = 0;
    logic [DW-1:0] last_wr = '0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hs4_bus_sender #(.DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .dest_bus(dest_bus), .word_in(word_in),
        .word_valid(word_valid), .ser_free(ser_free),
        .rdr_req_async(rdr_req_async), .dn_ready(dn_ready),
        .snd_flag(snd_flag), .wr_stb(wr_stb), .wr_data(wr_data),
        .proto_err(proto_err)
    );

    always @(negedge clk) begin
        if (wr_stb) begin
            wr_cnt++;
            last_wr = wr_data;
        end
        if (proto_err) err_cnt++;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic push_word(input logic [DW-1:0] w);
        word_in = w;
        word_valid = 1'b1;
        @(negedge clk);
        word_valid = 1'b0;
    endtask

    task automatic wait_flag(input logic v, input string req);
        int n = 0;
        while (snd_flag !== v && n < 50) begin
            @(negedge clk);
            n++;
        end
        check(req, snd_flag, v);
    endtask

    task automatic wait_writes(input int target, input string req);
        int n = 0;
        while (wr_cnt < target && n < 50) begin
            @(negedge clk);
            n++;
        end
        check(req, wr_cnt, target);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cyc(3);
        check("R1 flag in reset", snd_flag, 0);
        check("R1 wr_stb in reset", wr_stb, 0);
        check("R1 proto_err in reset", proto_err, 0);
        rst_n = 1'b1;
        cyc(1);
        check("R1 flag after reset", snd_flag, 0);
    endtask

    task automatic t_basic(input logic [DW-1:0] w);
        int base = wr_cnt;
        push_word(w);
        cyc(5);
        check("R4 no offer without request", snd_flag, 0);
        rdr_req_async = 1'b1;
        wait_flag(1'b1, "R4 offer after request");
        wait_writes(base + 1, "R5 one write");
        check("R5 written data", last_wr, w);
        cyc(6);
        check("R6 flag held until request falls", snd_flag, 1);
        check("R8 no second write before receipt", wr_cnt, base + 1);
        rdr_req_async = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        check("R7 flag still high after two edges", snd_flag, 1);
        @(negedge clk);
        check("R6 R7 flag low after third edge", snd_flag, 0);
    endtask

    task automatic t_ser_free();
        int base = wr_cnt;
        ser_free = 1'b0;
        push_word(32'hC0FFEE01);
        rdr_req_async = 1'b1;
        cyc(8);
        check("R4 no offer while transmitter busy", snd_flag, 0);
        ser_free = 1'b1;
        wait_flag(1'b1, "R4 offer once transmitter free");
        wait_writes(base + 1, "R4 write after transmitter free");
        rdr_req_async = 1'b0;
        wait_flag(1'b0, "R6 close after transmitter test");
    endtask

    task automatic t_ready_gate();
        int base = wr_cnt;
        dn_ready = 1'b0;
        push_word(32'h5A5A0F0F);
        rdr_req_async = 1'b1;
        wait_flag(1'b1, "R5 offer with downstream busy");
        cyc(6);
        check("R5 no write while downstream busy", wr_cnt, base);
        dn_ready = 1'b1;
        wait_writes(base + 1, "R5 write after downstream ready");
        check("R5 gated data", last_wr, 32'h5A5A0F0F);
        rdr_req_async = 1'b0;
        wait_flag(1'b0, "R6 close after gate test");
    endtask

    task automatic t_busy_strobe();
        int base = wr_cnt;
        push_word(32'hAAAA0001);
        cyc(2);
        push_word(32'hBBBB0002);
        rdr_req_async = 1'b1;
        wait_writes(base + 1, "R2 held word written");
        check("R2 later strobe ignored", last_wr, 32'hAAAA0001);
        rdr_req_async = 1'b0;
        wait_flag(1'b0, "R6 close after strobe test");
        cyc(4);
        rdr_req_async = 1'b1;
        cyc(10);
        check("R8 no offer without new word", snd_flag, 0);
        check("R8 no extra write", wr_cnt, base + 1);
        rdr_req_async = 1'b0;
        cyc(4);
    endtask

    task automatic t_link();
        int base = wr_cnt;
        dest_bus = 1'b0;
        push_word(32'h11112222);
        rdr_req_async = 1'b1;
        cyc(10);
        check("R3 link flag low", snd_flag, 0);
        check("R3 link no write", wr_cnt, base);
        rdr_req_async = 1'b0;
        cyc(4);
        dest_bus = 1'b1;
        rdr_req_async = 1'b1;
        cyc(10);
        check("R3 link word not retained", wr_cnt, base);
        rdr_req_async = 1'b0;
        cyc(4);
    endtask

    task automatic t_abort();
        int base = wr_cnt;
        int ebase = err_cnt;
        dn_ready = 1'b0;
        push_word(32'hDEAD0009);
        rdr_req_async = 1'b1;
        wait_flag(1'b1, "R9 offer before withdraw");
        rdr_req_async = 1'b0;
        cyc(6);
        check("R9 one error pulse", err_cnt, ebase + 1);
        check("R9 flag low after withdraw", snd_flag, 0);
        check("R9 no write on withdraw", wr_cnt, base);
        dn_ready = 1'b1;
        rdr_req_async = 1'b1;
        wait_writes(base + 1, "R9 retry write");
        check("R9 retained data", last_wr, 32'hDEAD0009);
        check("R9 no error on good cycle", err_cnt, ebase + 1);
        rdr_req_async = 1'b0;
        wait_flag(1'b0, "R6 close after retry");
    endtask

    initial begin
        cyc(1);
        t_reset();
        t_basic(32'h12345678);
        t_basic(32'h9ABCDEF0);
        t_ser_free();
        t_ready_gate();
        t_busy_strobe();
        t_link();
        t_abort();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule